// File: doc/BRIEF.md
# Dual-Function Parallel Port Pin Multiplexer

This block sits between a row of eighteen I/O pads and the logic inside the chip. Two word-wide configuration registers, reached through a simple bus, choose for every pad whether it belongs to software as a general-purpose pin or is handed to an on-chip peripheral. The same direction bit has a second job. For a software pin it chooses between driving and sensing. For a peripheral pin it chooses which of two candidate peripheral functions owns the pad.

Each pin steers three things: the value driven to the pad, the pad's output enable, and the pad's input. In GPIO output mode the pad drives the externally held data-register bit. In GPIO input mode the pad is released and its level reaches software through a two-stage synchroniser. In peripheral mode the chosen function supplies its own value and enable and alone receives the pad input. A sideband input signals that a parallel-interface controller has taken the port. While it is set, the direction bits of the two lowest implemented positions are treated as zero.

The registers clear only on hard reset. A soft reset leaves the configuration in place and clears only the input synchroniser.

Top module: `pmux_port`

## Requirements
- R1: While hard_rst_n is low at a clock edge, both configuration registers clear, so each reads back as 0x00000000.
- R2: A soft reset (soft_rst_n low while hard_rst_n is high) leaves both configuration registers unchanged.
- R3: A write with bus_we high at address DIR_ADDR (default 6) loads the direction register, and one at DIR_ADDR+1 loads the assignment register, on the next clock edge. bus_rdata shows the addressed register combinationally, and any other address reads 0.
- R4: Data-word bits 31 to 18 (LSB-0 numbering) are reserved. They always read 0 and writes to them have no effect.
- R5: The pin with big-endian position n (14 to 31, position 0 being the word's MSB) uses data-word bit 31-n. Port index i = n-14 on the pin vectors therefore uses bus_wdata/bus_rdata bit 17-i.
- R6: When a pin's assignment bit is 0 and its effective direction bit is 1 (GPIO output), pad_oe is 1 and pad_out equals gpio_dout for that pin.
- R7: When a pin's assignment bit is 0 and its effective direction bit is 0 (GPIO input), pad_oe and pad_out are 0. gpio_din shows pad_in after two clock edges, and gpio_din is 0 for every pin that is not a GPIO input.
- R8: When a pin's assignment bit is 1 and its effective direction bit is 0, pad_out and pad_oe come from pf0_out and pf0_oe, pf0_in carries pad_in, and pf1_in is 0.
- R9: When a pin's assignment bit is 1 and its effective direction bit is 1, pad_out and pad_oe come from pf1_out and pf1_oe, pf1_in carries pad_in, and pf0_in is 0.
- R10: A pin that is not dedicated to a peripheral drives 0 on both pf0_in and pf1_in.
- R11: While pic_claim is 1, the direction bits of positions 14 and 15 (port indices 0 and 1) act as 0 in both modes. They still read back as written.
- R12: A hard or a soft reset clears the input synchroniser, so gpio_din is 0 on the cycle after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Hard reset, active low, synchronous |
| soft_rst_n | input | 1 | Soft reset, active low, synchronous |
| pic_claim | input | 1 | Port taken by the parallel-interface controller |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data |
| gpio_dout | input | 18 | Data-register value for GPIO output pins |
| gpio_din | output | 18 | Synchronised pad input for GPIO input pins |
| pf0_out | input | 18 | Peripheral function 0 output values |
| pf0_oe | input | 18 | Peripheral function 0 output enables |
| pf0_in | output | 18 | Pad input routed to function 0 |
| pf1_out | input | 18 | Peripheral function 1 output values |
| pf1_oe | input | 18 | Peripheral function 1 output enables |
| pf1_in | output | 18 | Pad input routed to function 1 |
| pad_in | input | 18 | Pad input levels |
| pad_out | output | 18 | Pad output values |
| pad_oe | output | 18 | Pad output enables |

## Verification
The assertions check on every cycle that GPIO input pins float and GPIO output pins drive the data bit, and that an unselected peripheral never sees a pad. They also check that the reserved read bits stay zero, that the claimed pins fall back to function 0 or input, and that registers follow writes and survive soft reset. Only the bench's scenarios can show the bit-reversed mapping between word bits and port pins, the exact two-edge latency of the synchroniser, and the mixed per-pin configurations. The bench checks these against a model of its own.

// File: rtl/pmux_pkg.sv
package pmux_pkg;

  localparam int WORD_W    = 32;
  localparam int FIRST_POS = 14;
  localparam int NPIN      = WORD_W - FIRST_POS;

  typedef enum logic [1:0] {
    MODE_GPIO_IN  = 2'd0,
    MODE_GPIO_OUT = 2'd1,
    MODE_PF0      = 2'd2,
    MODE_PF1      = 2'd3
  } pin_mode_e;

  // Big-endian position FIRST_POS+i lives at LSB-0 bit WORD_W-1-(FIRST_POS+i).
  function automatic logic [NPIN-1:0] word_to_pins(input logic [WORD_W-1:0] w);
    logic [NPIN-1:0] p;
    for (int i = 0; i < NPIN; i++) begin
      p[i] = w[WORD_W-1-FIRST_POS-i];
    end
    return p;
  endfunction

  function automatic logic [WORD_W-1:0] pins_to_word(input logic [NPIN-1:0] p);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int i = 0; i < NPIN; i++) begin
      w[WORD_W-1-FIRST_POS-i] = p[i];
    end
    return w;
  endfunction

  function automatic pin_mode_e pin_mode(input logic dedicated, input logic dir);
    pin_mode_e m;
    case ({dedicated, dir})
      2'b00:   m = MODE_GPIO_IN;
      2'b01:   m = MODE_GPIO_OUT;
      2'b10:   m = MODE_PF0;
      default: m = MODE_PF1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pmux_regs.sv
module pmux_regs
  import pmux_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 6
) (
  input  logic              clk,
  input  logic              hard_rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [NPIN-1:0]   dir_q,
  output logic [NPIN-1:0]   par_q,
  output logic              dir_wr,
  output logic              par_wr
);

  localparam logic [ADDR_W-1:0] PAR_ADDR = DIR_ADDR + 1'b1;

  logic [NPIN-1:0] wr_pins;

  assign dir_wr  = bus_we && (bus_addr == DIR_ADDR);
  assign par_wr  = bus_we && (bus_addr == PAR_ADDR);
  assign wr_pins = word_to_pins(bus_wdata);

  // Soft reset is deliberately not an input: configuration survives it.
  always_ff @(posedge clk) begin
    if (!hard_rst_n) begin
      dir_q <= '0;
      par_q <= '0;
    end else begin
      if (dir_wr) dir_q <= wr_pins;
      if (par_wr) par_q <= wr_pins;
    end
  end

  always_comb begin
    if (bus_addr == DIR_ADDR)      bus_rdata = pins_to_word(dir_q);
    else if (bus_addr == PAR_ADDR) bus_rdata = pins_to_word(par_q);
    else                           bus_rdata = '0;
  end

endmodule

// File: rtl/pmux_sync.sv
module pmux_sync #(
  parameter int W      = 18,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         hard_rst_n,
  input  logic         soft_rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES+1];

  assign stage[0] = d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!hard_rst_n || !soft_rst_n) stage[s+1] <= '0;
      else                            stage[s+1] <= stage[s];
    end
  end

  assign q = stage[STAGES];

endmodule

// File: rtl/pmux_pin.sv
module pmux_pin
  import pmux_pkg::*;
(
  input  logic dedicated,
  input  logic dir_eff,
  input  logic gpio_out,
  input  logic sync_in,
  input  logic pad_in,
  input  logic f0_out,
  input  logic f0_oe,
  input  logic f1_out,
  input  logic f1_oe,
  output logic pad_out,
  output logic pad_oe,
  output logic gpio_in,
  output logic f0_in,
  output logic f1_in
);

  pin_mode_e mode;

  assign mode = pin_mode(dedicated, dir_eff);

  always_comb begin
    pad_out = 1'b0;
    pad_oe  = 1'b0;
    gpio_in = 1'b0;
    f0_in   = 1'b0;
    f1_in   = 1'b0;
    case (mode)
      MODE_GPIO_IN:  gpio_in = sync_in;
      MODE_GPIO_OUT: begin
        pad_out = gpio_out;
        pad_oe  = 1'b1;
      end
      MODE_PF0: begin
        pad_out = f0_out;
        pad_oe  = f0_oe;
        f0_in   = pad_in;
      end
      default: begin
        pad_out = f1_out;
        pad_oe  = f1_oe;
        f1_in   = pad_in;
      end
    endcase
  end

endmodule

// File: rtl/pmux_port.sv
module pmux_port
  import pmux_pkg::*;
#(
  parameter int                ADDR_W     = 4,
  parameter logic [ADDR_W-1:0] DIR_ADDR   = 6,
  parameter int                CLAIM_PINS = 2,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              hard_rst_n,
  input  logic              soft_rst_n,
  input  logic              pic_claim,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [NPIN-1:0]   gpio_dout,
  output logic [NPIN-1:0]   gpio_din,
  input  logic [NPIN-1:0]   pf0_out,
  input  logic [NPIN-1:0]   pf0_oe,
  output logic [NPIN-1:0]   pf0_in,
  input  logic [NPIN-1:0]   pf1_out,
  input  logic [NPIN-1:0]   pf1_oe,
  output logic [NPIN-1:0]   pf1_in,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe
);

  // Named internal events, visible to the bound checker.
  logic [NPIN-1:0] dir_q;
  logic [NPIN-1:0] par_q;
  logic [NPIN-1:0] dir_eff;
  logic [NPIN-1:0] sync_q;
  logic            dir_wr;
  logic            par_wr;

  pmux_regs #(
    .ADDR_W   (ADDR_W),
    .DIR_ADDR (DIR_ADDR)
  ) u_regs (
    .clk        (clk),
    .hard_rst_n (hard_rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .dir_q      (dir_q),
    .par_q      (par_q),
    .dir_wr     (dir_wr),
    .par_wr     (par_wr)
  );

  pmux_sync #(
    .W      (NPIN),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk        (clk),
    .hard_rst_n (hard_rst_n),
    .soft_rst_n (soft_rst_n),
    .d          (pad_in),
    .q          (sync_q)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    if (i < CLAIM_PINS) begin : g_claimable
      assign dir_eff[i] = dir_q[i] & ~pic_claim;
    end else begin : g_plain
      assign dir_eff[i] = dir_q[i];
    end

    pmux_pin u_pin (
      .dedicated (par_q[i]),
      .dir_eff   (dir_eff[i]),
      .gpio_out  (gpio_dout[i]),
      .sync_in   (sync_q[i]),
      .pad_in    (pad_in[i]),
      .f0_out    (pf0_out[i]),
      .f0_oe     (pf0_oe[i]),
      .f1_out    (pf1_out[i]),
      .f1_oe     (pf1_oe[i]),
      .pad_out   (pad_out[i]),
      .pad_oe    (pad_oe[i]),
      .gpio_in   (gpio_din[i]),
      .f0_in     (pf0_in[i]),
      .f1_in     (pf1_in[i])
    );
  end

endmodule

// File: rtl/pmux_port_chk.sv
module pmux_port_chk
  import pmux_pkg::*;
#(
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 6
) (
  input logic              clk,
  input logic              hard_rst_n,
  input logic              soft_rst_n,
  input logic              pic_claim,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic [NPIN-1:0]   gpio_dout,
  input logic [NPIN-1:0]   pf0_out,
  input logic [NPIN-1:0]   pf0_oe,
  input logic [NPIN-1:0]   pf0_in,
  input logic [NPIN-1:0]   pf1_in,
  input logic [NPIN-1:0]   pad_out,
  input logic [NPIN-1:0]   pad_oe,
  input logic [NPIN-1:0]   dir_q,
  input logic [NPIN-1:0]   par_q,
  input logic [NPIN-1:0]   dir_eff
);

  localparam logic [ADDR_W-1:0] PAR_ADDR = DIR_ADDR + 1'b1;

  a_r1_hard_clear: assert property (@(posedge clk)
    !hard_rst_n |=> (dir_q == '0 && par_q == '0));

  a_r2_soft_keeps: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (!soft_rst_n && !bus_we) |=> (dir_q == $past(dir_q) && par_q == $past(par_q)));

  a_r3_dir_write: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (bus_we && bus_addr == DIR_ADDR) |=> dir_q == word_to_pins($past(bus_wdata)));

  a_r3_par_write: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (bus_we && bus_addr == PAR_ADDR) |=> par_q == word_to_pins($past(bus_wdata)));

  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!hard_rst_n)
    bus_rdata[WORD_W-1:NPIN] == '0);

  a_r6_gpio_drive: assert property (@(posedge clk) disable iff (!hard_rst_n)
    ((((pad_out ^ gpio_dout) | ~pad_oe) & ~par_q & dir_eff) == '0));

  a_r7_gpio_float: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (((pad_out | pad_oe) & ~par_q & ~dir_eff) == '0));

  a_r8_r9_one_listener: assert property (@(posedge clk) disable iff (!hard_rst_n)
    ((pf0_in & pf1_in) == '0 && (pf0_in & dir_eff) == '0 && (pf1_in & ~dir_eff) == '0));

  a_r10_gpio_no_periph: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (((pf0_in | pf1_in) & ~par_q) == '0));

  a_r11_claim_pf0: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (pic_claim && par_q[0]) |-> (pad_out[0] == pf0_out[0] && pad_oe[0] == pf0_oe[0]));

  a_r11_claim_input: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (pic_claim && !par_q[1]) |-> (pad_oe[1] == 1'b0));

endmodule

bind pmux_port pmux_port_chk #(
  .ADDR_W   (ADDR_W),
  .DIR_ADDR (DIR_ADDR)
) u_chk (
  .clk        (clk),
  .hard_rst_n (hard_rst_n),
  .soft_rst_n (soft_rst_n),
  .pic_claim  (pic_claim),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .gpio_dout  (gpio_dout),
  .pf0_out    (pf0_out),
  .pf0_oe     (pf0_oe),
  .pf0_in     (pf0_in),
  .pf1_in     (pf1_in),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .dir_q      (dir_q),
  .par_q      (par_q),
  .dir_eff    (dir_eff)
);

// File: tb/tb_pmux_port.sv
module tb_pmux_port;

  localparam int N = 18;
  localparam logic [3:0] A_DIR = 4'd6;
  localparam logic [3:0] A_PAR = 4'd7;

  typedef struct packed {
    logic [N-1:0] par;
    logic [N-1:0] dir;
    logic         claim;
    logic [N-1:0] pad;
    logic [N-1:0] dout;
    logic [N-1:0] p0o;
    logic [N-1:0] p0e;
    logic [N-1:0] p1o;
    logic [N-1:0] p1e;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{18'h00000, 18'h3FFFF, 1'b0, 18'h0F0F0, 18'h2A5A5, 18'h00000, 18'h00000, 18'h00000, 18'h00000},
    '{18'h00000, 18'h00000, 1'b0, 18'h15A3C, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF},
    '{18'h3FFFF, 18'h00000, 1'b0, 18'h2C3A1, 18'h3FFFF, 18'h12345, 18'h3F00F, 18'h3FFFF, 18'h3FFFF},
    '{18'h3FFFF, 18'h3FFFF, 1'b0, 18'h0BEEF, 18'h00000, 18'h3FFFF, 18'h3FFFF, 18'h2F0F1, 18'h1C3C7},
    '{18'h3FFFF, 18'h3FFFF, 1'b1, 18'h3FFFF, 18'h00000, 18'h00001, 18'h00003, 18'h3FFFE, 18'h3FFFF},
    '{18'h00000, 18'h00003, 1'b1, 18'h00003, 18'h3FFFF, 18'h00000, 18'h00000, 18'h00000, 18'h00000},
    '{18'h0F0F3, 18'h33CC3, 1'b1, 18'h2B6D9, 18'h1E1E1, 18'h35555, 18'h0FFFF, 18'h2AAAA, 18'h3FF00}
  };

  logic          clk = 1'b0;
  logic          hard_rst_n = 1'b0;
  logic          soft_rst_n = 1'b1;
  logic          pic_claim = 1'b0;
  logic          bus_we = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  gpio_dout = '0, gpio_din;
  logic [N-1:0]  pf0_out = '0, pf0_oe = '0, pf0_in;
  logic [N-1:0]  pf1_out = '0, pf1_oe = '0, pf1_in;
  logic [N-1:0]  pad_in = '0, pad_out, pad_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pmux_port dut (
    .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst_n(soft_rst_n), .pic_claim(pic_claim),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gpio_dout(gpio_dout), .gpio_din(gpio_din),
    .pf0_out(pf0_out), .pf0_oe(pf0_oe), .pf0_in(pf0_in),
    .pf1_out(pf1_out), .pf1_oe(pf1_oe), .pf1_in(pf1_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // Port index i sits at word bit 17-i: reverse the low 18 bits.
  function automatic logic [31:0] to_word(input logic [N-1:0] p);
    logic [31:0] w = '0;
    for (int k = 0; k < N; k++) w[N-1-k] = p[k];
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end

  initial begin
    logic [31:0] r;
    logic [N-1:0] e_out, e_oe, e_p0, e_p1, e_g;

    repeat (3) @(negedge clk);
    // R1 reset state
    rd(A_DIR, r); check("R1 dir after hard reset", r, 32'h0);
    rd(A_PAR, r); check("R1 par after hard reset", r, 32'h0);
    hard_rst_n = 1'b1;
    @(negedge clk);
    check("R7 pads float after reset", {14'h0, pad_oe}, 32'h0);

    // R3 R4: reserved bits ignore writes
    wr(A_DIR, 32'hFFFF_FFFF);
    rd(A_DIR, r); check("R4 reserved bits read zero", r, 32'h0003_FFFF);
    rd(A_PAR, r); check("R3 par untouched by dir write", r, 32'h0);
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, r);  check("R3 unmapped address reads zero", r, 32'h0);
    rd(A_PAR, r); check("R3 unmapped write has no effect", r, 32'h0);

    // R5: word bit 17 is position 14 = port index 0
    wr(A_DIR, 32'h0);
    wr(A_PAR, 32'h0002_0000);
    pf0_out = 18'h3FFFF; pf0_oe = 18'h3FFFF;
    @(negedge clk);
    check("R5 bit17 maps to index 0 oe", {14'h0, pad_oe}, 32'h1);
    wr(A_PAR, 32'h0000_0001);
    @(negedge clk);
    check("R5 bit0 maps to index 17 oe", {14'h0, pad_oe}, 32'h20000);
    wr(A_PAR, 32'h0);
    pf0_out = '0; pf0_oe = '0;

    // Table walk: R6 R7 R8 R9 R10 R11
    for (int v = 0; v < NV; v++) begin
      wr(A_DIR, to_word(VEC[v].dir));
      wr(A_PAR, to_word(VEC[v].par));
      pic_claim = VEC[v].claim; pad_in = VEC[v].pad; gpio_dout = VEC[v].dout;
      pf0_out = VEC[v].p0o; pf0_oe = VEC[v].p0e; pf1_out = VEC[v].p1o; pf1_oe = VEC[v].p1e;
      repeat (3) @(negedge clk);
      for (int i = 0; i < N; i++) begin
        logic d;
        d = VEC[v].dir[i] && !(VEC[v].claim && i < 2);
        e_out[i] = 1'b0; e_oe[i] = 1'b0; e_p0[i] = 1'b0; e_p1[i] = 1'b0; e_g[i] = 1'b0;
        if (!VEC[v].par[i]) begin
          if (d) begin e_out[i] = VEC[v].dout[i]; e_oe[i] = 1'b1; end
          else e_g[i] = VEC[v].pad[i];
        end else if (!d) begin
          e_out[i] = VEC[v].p0o[i]; e_oe[i] = VEC[v].p0e[i]; e_p0[i] = VEC[v].pad[i];
        end else begin
          e_out[i] = VEC[v].p1o[i]; e_oe[i] = VEC[v].p1e[i]; e_p1[i] = VEC[v].pad[i];
        end
      end
      check($sformatf("R6 R8 R9 R11 pad_out vec%0d", v), {14'h0, pad_out}, {14'h0, e_out});
      check($sformatf("R6 R7 R8 R9 R11 pad_oe vec%0d", v), {14'h0, pad_oe}, {14'h0, e_oe});
      check($sformatf("R8 R10 pf0_in vec%0d", v), {14'h0, pf0_in}, {14'h0, e_p0});
      check($sformatf("R9 R10 pf1_in vec%0d", v), {14'h0, pf1_in}, {14'h0, e_p1});
      check($sformatf("R7 gpio_din vec%0d", v), {14'h0, gpio_din}, {14'h0, e_g});
      rd(A_DIR, r);
      check($sformatf("R3 R11 dir readback vec%0d", v), r, to_word(VEC[v].dir));
    end

    // R7: two-edge latency on an all-input port
    pic_claim = 1'b0;
    wr(A_DIR, 32'h0); wr(A_PAR, 32'h0);
    pad_in = 18'h00000;
    repeat (3) @(negedge clk);
    pad_in = 18'h3C3C3;
    @(negedge clk);
    check("R7 gpio_din after one edge", {14'h0, gpio_din}, 32'h0);
    @(negedge clk);
    check("R7 gpio_din after two edges", {14'h0, gpio_din}, 32'h3C3C3);

    // R2 R12: soft reset keeps registers, clears synchroniser
    wr(A_DIR, to_word(18'h00F0F));
    wr(A_PAR, to_word(18'h30000));
    soft_rst_n = 1'b0;
    @(negedge clk);
    soft_rst_n = 1'b1;
    check("R12 gpio_din cleared by soft reset", {14'h0, gpio_din}, 32'h0);
    rd(A_DIR, r); check("R2 dir kept over soft reset", r, to_word(18'h00F0F));
    rd(A_PAR, r); check("R2 par kept over soft reset", r, to_word(18'h30000));

    // R1 R12: hard reset clears everything
    hard_rst_n = 1'b0;
    @(negedge clk);
    hard_rst_n = 1'b1;
    check("R12 gpio_din cleared by hard reset", {14'h0, gpio_din}, 32'h0);
    rd(A_DIR, r); check("R1 dir cleared by hard reset", r, 32'h0);
    rd(A_PAR, r); check("R1 par cleared by hard reset", r, 32'h0);

    done = 1'b1;
    report();
  end

endmodule